// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 64-bit privileged control registers of a processor core. Software-level microcode reaches them through one request port: a valid strobe, a write enable, a 6-bit register index and a 64-bit write word. Each register has its own write rule. Some keep the whole word. Some keep only a masked set of bits. Some return to zero on every write. Some refuse writes, and some refuse reads. Every request gets a registered response one cycle later, which carries read data and a fault flag.

Several registers do more than store a value. The cycle-count register returns its stored upper half joined to a free-running counter. The data page-entry register reads back as a repacked entry. Writes to the translation-buffer control registers produce single-cycle strobes, each with a payload, for a translation buffer outside this block. A tag write builds a complete entry from the staged page-entry register and the address-space register. If the staged granularity-hint field is not zero, the block raises an error instead of the insert.

Top module: `ctl_reg_bank`

## Requirements
- R1: Indices 0 to 24 are scratch registers that keep the full 64-bit write word and read it back unchanged. Each register is independent of the others. Every request (req_valid_i high at a clock edge) gives rsp_valid_o high on the next cycle only, and rsp_rdata_o and rsp_fault_o are valid in that same cycle.
- R2: Index 25, the exception address register, stores the write word with bit 1 forced to zero.
- R3: Indices 26 and 27, the trap request and trap enable registers, keep bits [3:0]. Index 28, the priority level register, keeps bits [4:0]. Indices 29 and 30, the current mode and data mode registers, keep only bits [4:3].
- R4: Index 31, the software interrupt request register, keeps the write word ANDed with 0x7FFF0. Index 32, the instruction control register, uses the mask 0xFF_FFFF_0300. Index 33, the page-table base register, uses the mask 0xFFFF_FFFF_C000_0000. Index 48, the address-space register, keeps bits [63:57], and those bits are the 7-bit ASN.
- R5: A write to index 34 (exception summary) or index 35 (exception mask) leaves the register at zero, whatever the data. Such a write raises no fault.
- R6: Writes to indices 36 to 39 (read-only status) are refused with rsp_fault_o high and change nothing. Reads of these indices return zero with no fault.
- R7: Reads of indices 40 to 44 (write-only controls) raise rsp_fault_o and return zero. Writes to these indices raise no fault.
- R8: Indices 50 to 63 are unmapped, and any access to them raises rsp_fault_o. In every response with rsp_fault_o high, rsp_rdata_o is zero.
- R9: A read of index 46 returns the stored bits [63:32] in the upper half. The lower half holds a 32-bit counter that resets to zero and advances by one every clock, sampled at the request edge. A write to index 46 stores only the upper half.
- R10: A read of index 47 returns only the entry fields of the stored word: page number [58:32], read enables [11:8], write enables [15:12], fault-on-read bit 1, fault-on-write bit 2 and address-space-match bit 4. The current ASN is ORed in at [63:57]. All other stored bits, including the granularity hint [6:5], read as zero.
- R11: A write to index 43 pulses tb_flush_all_o, and a write to index 44 pulses tb_flush_proc_o. Each pulse lasts one cycle and comes in the response cycle.
- R12: A write to index 45 stores the address, which reads back unchanged. It pulses tb_flush_one_o with tb_addr_o set to the address and tb_asn_o set to the current ASN.
- R13: A write to index 49 stores the tag. If the staged granularity hint (index 47 bits [6:5]) is zero, the write pulses tb_insert_o with tb_tag_o set to the written tag and tb_entry_o set to the repacked entry of R10. Otherwise the write pulses rsp_err_o and gives no insert.
- R14: After reset every register reads zero and all response and strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_idx_i | input | 6 | Register index |
| req_wdata_i | input | 64 | Write word |
| rsp_valid_o | output | 1 | Response valid (one cycle after request) |
| rsp_rdata_o | output | 64 | Read data, zero for writes and faults |
| rsp_fault_o | output | 1 | Access refused |
| rsp_err_o | output | 1 | Tag write with nonzero granularity hint |
| tb_flush_all_o | output | 1 | Invalidate-all strobe |
| tb_flush_proc_o | output | 1 | Invalidate-process strobe |
| tb_flush_one_o | output | 1 | Invalidate-single strobe |
| tb_insert_o | output | 1 | Entry insert strobe |
| tb_addr_o | output | 64 | Address for invalidate-single |
| tb_asn_o | output | 7 | ASN for invalidate-single |
| tb_tag_o | output | 64 | Tag for insert |
| tb_entry_o | output | 64 | Packed entry for insert |

## Verification
A wrong mask or a wrong clear rule in a register is visible on the first read of that register, one cycle after the read request. A wrong fault classification shows on rsp_fault_o in the response cycle of the bad access. A corrupted staged entry or ASN does not appear at the point of the fault. It first appears on tb_entry_o or tb_asn_o at the next tag or invalidate-single write, or on the next read of index 47. For that reason the bench reads these registers back directly and also checks the strobe payloads. A counter that skips or stalls is caught by checking the difference between two cycle-register reads taken a known number of cycles apart.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int DATA_W    = 64;
  localparam int IDX_W     = 6;
  localparam int ASN_W     = 7;
  localparam int ASN_LSB   = DATA_W - ASN_W;
  localparam int N_SCRATCH = 25;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam idx_t IX_EXC_ADDR  = 6'd25;
  localparam idx_t IX_TRAP_REQ  = 6'd26;
  localparam idx_t IX_TRAP_EN   = 6'd27;
  localparam idx_t IX_IPL       = 6'd28;
  localparam idx_t IX_CUR_MODE  = 6'd29;
  localparam idx_t IX_DATA_MODE = 6'd30;
  localparam idx_t IX_SWINT     = 6'd31;
  localparam idx_t IX_ICTL      = 6'd32;
  localparam idx_t IX_VPTB      = 6'd33;
  localparam idx_t IX_EXC_SUM   = 6'd34;
  localparam idx_t IX_EXC_MASK  = 6'd35;
  localparam idx_t IX_RO_FIRST  = 6'd36;
  localparam idx_t IX_RO_LAST   = 6'd39;
  localparam idx_t IX_WO_FIRST  = 6'd40;
  localparam idx_t IX_INV_ALL   = 6'd43;
  localparam idx_t IX_INV_PROC  = 6'd44;
  localparam idx_t IX_INV_ONE   = 6'd45;
  localparam idx_t IX_CYCLE     = 6'd46;
  localparam idx_t IX_PTE       = 6'd47;
  localparam idx_t IX_ASN       = 6'd48;
  localparam idx_t IX_TAG       = 6'd49;
  localparam idx_t IX_LAST      = IX_TAG;

  localparam word_t M_EXC_ADDR = ~word_t'(64'h2);
  localparam word_t M_TRAP     = 64'hF;
  localparam word_t M_IPL      = 64'h1F;
  localparam word_t M_MODE     = 64'h18;
  localparam word_t M_SWINT    = 64'h7_FFF0;
  localparam word_t M_ICTL     = 64'hFF_FFFF_0300;
  localparam word_t M_VPTB     = 64'hFFFF_FFFF_C000_0000;

  // page-entry field positions (shared by staging and repacked read)
  localparam int PPN_LSB = 32, PPN_W = 27;
  localparam int RE_LSB  = 8,  WE_LSB = 12, EN_W = 4;
  localparam int FOR_BIT = 1,  FOW_BIT = 2, ASM_BIT = 4;
  localparam int GH_LSB  = 5,  GH_W = 2;

  function automatic logic idx_mapped(idx_t i);
    return i <= IX_LAST;
  endfunction

  function automatic logic idx_read_only(idx_t i);
    return (i >= IX_RO_FIRST) && (i <= IX_RO_LAST);
  endfunction

  function automatic logic idx_write_only(idx_t i);
    return (i >= IX_WO_FIRST) && (i <= IX_INV_PROC);
  endfunction

  function automatic word_t pack_entry(word_t pte, logic [ASN_W-1:0] asn);
    word_t r;
    r = '0;
    r[PPN_LSB +: PPN_W] = pte[PPN_LSB +: PPN_W];
    r[RE_LSB +: EN_W]   = pte[RE_LSB +: EN_W];
    r[WE_LSB +: EN_W]   = pte[WE_LSB +: EN_W];
    r[FOR_BIT]          = pte[FOR_BIT];
    r[FOW_BIT]          = pte[FOW_BIT];
    r[ASM_BIT]          = pte[ASM_BIT];
    r[ASN_LSB +: ASN_W] = r[ASN_LSB +: ASN_W] | asn;
    return r;
  endfunction

  function automatic logic gh_nonzero(word_t pte);
    return pte[GH_LSB +: GH_W] != '0;
  endfunction
endpackage

// File: rtl/ctl_scratch_file.sv
module ctl_scratch_file #(
  parameter int N  = 25,
  parameter int DW = 64,
  parameter int IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q[g] <= '0;
      else if (wr_en_i && idx_i == IW'(g))      q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (idx_i == IW'(i)) rdata_o = q[i];
  end
endmodule

// File: rtl/ctl_cycle_counter.sv
module ctl_cycle_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/ctl_tb_request.sv
module ctl_tb_request
  import ctl_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  idx_t             idx_i,
  input  word_t            wdata_i,
  input  word_t            pte_i,
  input  logic [ASN_W-1:0] asn_i,
  output logic             flush_all_o,
  output logic             flush_proc_o,
  output logic             flush_one_o,
  output logic             insert_o,
  output logic             gh_err_o,
  output word_t            addr_o,
  output logic [ASN_W-1:0] asn_o,
  output word_t            tag_o,
  output word_t            entry_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_all_o  <= 1'b0;
      flush_proc_o <= 1'b0;
      flush_one_o  <= 1'b0;
      insert_o     <= 1'b0;
      gh_err_o     <= 1'b0;
      addr_o       <= '0;
      asn_o        <= '0;
      tag_o        <= '0;
      entry_o      <= '0;
    end else begin
      flush_all_o  <= 1'b0;
      flush_proc_o <= 1'b0;
      flush_one_o  <= 1'b0;
      insert_o     <= 1'b0;
      gh_err_o     <= 1'b0;
      if (fire_i) begin
        unique case (idx_i)
          IX_INV_ALL:  flush_all_o  <= 1'b1;
          IX_INV_PROC: flush_proc_o <= 1'b1;
          IX_INV_ONE: begin
            flush_one_o <= 1'b1;
            addr_o      <= wdata_i;
            asn_o       <= asn_i;
          end
          IX_TAG: begin
            if (gh_nonzero(pte_i)) gh_err_o <= 1'b1;
            else begin
              insert_o <= 1'b1;
              tag_o    <= wdata_i;
              entry_o  <= pack_entry(pte_i, asn_i);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_we_i,
  input  logic [5:0]  req_idx_i,
  input  logic [63:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [63:0] rsp_rdata_o,
  output logic        rsp_fault_o,
  output logic        rsp_err_o,
  output logic        tb_flush_all_o,
  output logic        tb_flush_proc_o,
  output logic        tb_flush_one_o,
  output logic        tb_insert_o,
  output logic [63:0] tb_addr_o,
  output logic [6:0]  tb_asn_o,
  output logic [63:0] tb_tag_o,
  output logic [63:0] tb_entry_o
);
  localparam int HI_W = DATA_W - CNT_W;

  logic rd_fault, wr_fault, wr_ok, scr_sel;
  word_t scr_rdata, rd_word;
  logic [CNT_W-1:0] cnt;

  word_t exc_addr_q, swint_q, ictl_q, vptb_q, inv_one_q, pte_q, tag_q;
  logic [3:0] trap_req_q, trap_en_q;
  logic [4:0] ipl_q, cur_mode_q, data_mode_q;
  logic [HI_W-1:0]  cc_hi_q;
  logic [ASN_W-1:0] asn_q;

  assign rd_fault = !idx_mapped(req_idx_i) || idx_write_only(req_idx_i);
  assign wr_fault = !idx_mapped(req_idx_i) || idx_read_only(req_idx_i);
  assign wr_ok    = req_valid_i && req_we_i && !wr_fault;
  assign scr_sel  = req_idx_i < idx_t'(N_SCRATCH);

  ctl_scratch_file #(.N(N_SCRATCH), .DW(DATA_W), .IW(IDX_W)) u_scratch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_ok && scr_sel),
    .idx_i   (req_idx_i),
    .wdata_i (req_wdata_i),
    .rdata_o (scr_rdata)
  );

  ctl_cycle_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt)
  );

  ctl_tb_request u_tbreq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (wr_ok),
    .idx_i        (req_idx_i),
    .wdata_i      (req_wdata_i),
    .pte_i        (pte_q),
    .asn_i        (asn_q),
    .flush_all_o  (tb_flush_all_o),
    .flush_proc_o (tb_flush_proc_o),
    .flush_one_o  (tb_flush_one_o),
    .insert_o     (tb_insert_o),
    .gh_err_o     (rsp_err_o),
    .addr_o       (tb_addr_o),
    .asn_o        (tb_asn_o),
    .tag_o        (tb_tag_o),
    .entry_o      (tb_entry_o)
  );

  // per-register write rules
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_addr_q  <= '0;
      trap_req_q  <= '0;
      trap_en_q   <= '0;
      ipl_q       <= '0;
      cur_mode_q  <= '0;
      data_mode_q <= '0;
      swint_q     <= '0;
      ictl_q      <= '0;
      vptb_q      <= '0;
      inv_one_q   <= '0;
      pte_q       <= '0;
      tag_q       <= '0;
      cc_hi_q     <= '0;
      asn_q       <= '0;
    end else if (wr_ok && !scr_sel) begin
      unique case (req_idx_i)
        IX_EXC_ADDR:  exc_addr_q  <= req_wdata_i & M_EXC_ADDR;
        IX_TRAP_REQ:  trap_req_q  <= req_wdata_i[3:0];
        IX_TRAP_EN:   trap_en_q   <= req_wdata_i[3:0];
        IX_IPL:       ipl_q       <= req_wdata_i[4:0] & M_IPL[4:0];
        IX_CUR_MODE:  cur_mode_q  <= req_wdata_i[4:0] & M_MODE[4:0];
        IX_DATA_MODE: data_mode_q <= req_wdata_i[4:0] & M_MODE[4:0];
        IX_SWINT:     swint_q     <= req_wdata_i & M_SWINT;
        IX_ICTL:      ictl_q      <= req_wdata_i & M_ICTL;
        IX_VPTB:      vptb_q      <= req_wdata_i & M_VPTB;
        IX_INV_ONE:   inv_one_q   <= req_wdata_i;
        IX_CYCLE:     cc_hi_q     <= req_wdata_i[DATA_W-1 -: HI_W];
        IX_PTE:       pte_q       <= req_wdata_i;
        IX_ASN:       asn_q       <= req_wdata_i[ASN_LSB +: ASN_W];
        IX_TAG:       tag_q       <= req_wdata_i;
        default: ;  // clear-on-write and write-only controls keep no state
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    if (scr_sel) rd_word = scr_rdata;
    else begin
      unique case (req_idx_i)
        IX_EXC_ADDR:  rd_word = exc_addr_q;
        IX_TRAP_REQ:  rd_word = {60'b0, trap_req_q & M_TRAP[3:0]};
        IX_TRAP_EN:   rd_word = {60'b0, trap_en_q & M_TRAP[3:0]};
        IX_IPL:       rd_word = {59'b0, ipl_q};
        IX_CUR_MODE:  rd_word = {59'b0, cur_mode_q};
        IX_DATA_MODE: rd_word = {59'b0, data_mode_q};
        IX_SWINT:     rd_word = swint_q;
        IX_ICTL:      rd_word = ictl_q;
        IX_VPTB:      rd_word = vptb_q;
        IX_INV_ONE:   rd_word = inv_one_q;
        IX_CYCLE:     rd_word = {cc_hi_q, cnt};
        IX_PTE:       rd_word = pack_entry(pte_q, asn_q);
        IX_ASN:       rd_word = {asn_q, {ASN_LSB{1'b0}}};
        IX_TAG:       rd_word = tag_q;
        default:      rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= req_valid_i && (req_we_i ? wr_fault : rd_fault);
      rsp_rdata_o <= (req_valid_i && !req_we_i && !rd_fault) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/ctl_reg_bank_chk.sv
module ctl_reg_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_we_i,
  input logic [63:0] req_wdata_i,
  input logic        rsp_valid_o,
  input logic [63:0] rsp_rdata_o,
  input logic        rsp_fault_o,
  input logic        rsp_err_o,
  input logic        tb_flush_all_o,
  input logic        tb_flush_proc_o,
  input logic        tb_flush_one_o,
  input logic        tb_insert_o,
  input logic [63:0] tb_addr_o,
  input logic [63:0] tb_tag_o
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R8
  fault_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_rdata_o == 64'd0);
  // R11
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tb_flush_all_o, tb_flush_proc_o, tb_flush_one_o, tb_insert_o, rsp_err_o}));
  // R11
  strobe_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_flush_all_o || tb_flush_proc_o || tb_flush_one_o || tb_insert_o)
      |-> $past(req_valid_i && req_we_i) && !rsp_fault_o);
  // R12
  flush_one_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_flush_one_o |-> tb_addr_o == $past(req_wdata_i));
  // R13
  insert_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_insert_o |-> tb_tag_o == $past(req_wdata_i));
endmodule

bind ctl_reg_bank ctl_reg_bank_chk u_chk (.*);

// File: tb/ctl_reg_bank_test.sv
module ctl_reg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [5:0]  req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_fault, rsp_err;
  logic [63:0] rsp_rdata;
  logic        fl_all, fl_proc, fl_one, ins;
  logic [63:0] tb_addr, tb_tag, tb_entry;
  logic [6:0]  tb_asn;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // sampled response
  logic        s_valid, s_fault, s_err, s_all, s_proc, s_one, s_ins;
  logic [63:0] s_rdata, s_addr, s_tag, s_entry;
  logic [6:0]  s_asn;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_reg_bank uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_idx_i(req_idx), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_fault_o(rsp_fault), .rsp_err_o(rsp_err),
    .tb_flush_all_o(fl_all), .tb_flush_proc_o(fl_proc), .tb_flush_one_o(fl_one), .tb_insert_o(ins),
    .tb_addr_o(tb_addr), .tb_asn_o(tb_asn), .tb_tag_o(tb_tag), .tb_entry_o(tb_entry)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(logic we, logic [5:0] idx, logic [63:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_idx = idx; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    s_valid = rsp_valid; s_fault = rsp_fault; s_err = rsp_err; s_rdata = rsp_rdata;
    s_all = fl_all; s_proc = fl_proc; s_one = fl_one; s_ins = ins;
    s_addr = tb_addr; s_asn = tb_asn; s_tag = tb_tag; s_entry = tb_entry;
  endtask

  task automatic wr(logic [5:0] idx, logic [63:0] d); access(1'b1, idx, d); endtask
  task automatic rd(logic [5:0] idx); access(1'b0, idx, 64'd0); endtask

  task automatic t_reset;
    @(negedge clk);
    check("R14", "valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R14", "strobes after reset", {59'd0, fl_all, fl_proc, fl_one, ins, rsp_err}, 64'd0);
    rd(6'd24);  check("R14", "base reset", s_rdata, 64'd0);
    rd(6'd47);  check("R14", "pte reset", s_rdata, 64'd0);
    rd(6'd46);  check("R14", "cycle hi reset", s_rdata >> 32, 64'd0);
  endtask

  task automatic t_scratch;
    wr(6'd0, 64'hDEAD_BEEF_0123_4567);
    check("R1", "write response valid", {63'd0, s_valid}, 64'd1);
    check("R1", "write fault", {63'd0, s_fault}, 64'd0);
    wr(6'd13, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(6'd24, 64'h8000_0000_0000_0001);
    rd(6'd0);  check("R1", "scratch 0", s_rdata, 64'hDEAD_BEEF_0123_4567);
    rd(6'd13); check("R1", "scratch 13", s_rdata, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(6'd24); check("R1", "base", s_rdata, 64'h8000_0000_0000_0001);
    rd(6'd1);  check("R1", "untouched scratch 1", s_rdata, 64'd0);
    @(negedge clk);
    check("R1", "valid drops after one cycle", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_masks;
    logic [63:0] ones = '1;
    wr(6'd25, ones); rd(6'd25); check("R2", "exc addr bit1", s_rdata, ~64'h2);
    wr(6'd26, ones); rd(6'd26); check("R3", "trap req", s_rdata, 64'hF);
    wr(6'd27, 64'h35); rd(6'd27); check("R3", "trap en", s_rdata, 64'h5);
    wr(6'd28, ones); rd(6'd28); check("R3", "ipl", s_rdata, 64'h1F);
    wr(6'd29, ones); rd(6'd29); check("R3", "cur mode", s_rdata, 64'h18);
    wr(6'd30, 64'h0F); rd(6'd30); check("R3", "data mode", s_rdata, 64'h08);
    wr(6'd31, ones); rd(6'd31); check("R4", "swint", s_rdata, 64'h7_FFF0);
    wr(6'd32, ones); rd(6'd32); check("R4", "ictl", s_rdata, 64'hFF_FFFF_0300);
    wr(6'd33, ones); rd(6'd33); check("R4", "vptb", s_rdata, 64'hFFFF_FFFF_C000_0000);
    wr(6'd48, ones); rd(6'd48); check("R4", "asn reg", s_rdata, 64'hFE00_0000_0000_0000);
  endtask

  task automatic t_clear_and_faults;
    wr(6'd34, 64'h1234); check("R5", "exc sum write fault", {63'd0, s_fault}, 64'd0);
    rd(6'd34); check("R5", "exc sum cleared", s_rdata, 64'd0);
    wr(6'd35, '1); rd(6'd35); check("R5", "exc mask cleared", s_rdata, 64'd0);
    wr(6'd37, 64'h55); check("R6", "ro write fault", {63'd0, s_fault}, 64'd1);
    rd(6'd37); check("R6", "ro read no fault", {63'd0, s_fault}, 64'd0);
    check("R6", "ro read data", s_rdata, 64'd0);
    wr(6'd40, 64'h77); check("R7", "wo write no fault", {63'd0, s_fault}, 64'd0);
    rd(6'd40); check("R7", "wo read fault", {63'd0, s_fault}, 64'd1);
    check("R7", "wo read data", s_rdata, 64'd0);
    rd(6'd44); check("R7", "inv proc read fault", {63'd0, s_fault}, 64'd1);
    wr(6'd55, 64'h1); check("R8", "unmapped write fault", {63'd0, s_fault}, 64'd1);
    rd(6'd63); check("R8", "unmapped read fault", {63'd0, s_fault}, 64'd1);
    check("R8", "unmapped read data", s_rdata, 64'd0);
    rd(6'd0);  check("R8", "scratch untouched by faults", s_rdata, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_cycle;
    logic [31:0] c0;
    wr(6'd46, 64'h1234_5678_9ABC_DEF0);
    rd(6'd46);
    check("R9", "cycle upper", s_rdata >> 32, 64'h1234_5678);
    c0 = s_rdata[31:0];
    repeat (5) @(negedge clk);
    rd(6'd46);
    check("R9", "cycle delta", {32'd0, s_rdata[31:0] - c0}, 64'd7);
  endtask

  task automatic t_pte_insert;
    logic [63:0] pte, exp;
    // ppn 0x5A5A5A5, re A, we 5, for 1, fow 0, asm 1, junk bits 0 and 20
    pte = (64'h5A5A5A5 << 32) | (64'hA << 8) | (64'h5 << 12) | 64'h2 | 64'h10 | 64'h1 | (64'h1 << 20);
    wr(6'd48, 64'hAB00_0000_0000_0000);   // ASN 0x55
    wr(6'd47, pte);
    exp = (64'h5A5A5A5 << 32) | (64'hA << 8) | (64'h5 << 12) | 64'h2 | 64'h10 | (64'h55 << 57);
    rd(6'd47); check("R10", "pte repack", s_rdata, exp);
    wr(6'd49, 64'hCAFE_0000_1234_8000);
    check("R13", "insert strobe", {63'd0, s_ins}, 64'd1);
    check("R13", "insert tag", s_tag, 64'hCAFE_0000_1234_8000);
    check("R13", "insert entry", s_entry, exp);
    check("R13", "no err", {63'd0, s_err}, 64'd0);
    @(negedge clk);
    check("R13", "insert one cycle", {63'd0, ins}, 64'd0);
    wr(6'd47, pte | (64'h1 << 5));
    rd(6'd47); check("R10", "gh hidden on read", s_rdata, exp);
    wr(6'd49, 64'h1111);
    check("R13", "gh err", {63'd0, s_err}, 64'd1);
    check("R13", "gh no insert", {63'd0, s_ins}, 64'd0);
    rd(6'd49); check("R13", "tag stored", s_rdata, 64'h1111);
  endtask

  task automatic t_flush;
    wr(6'd43, 64'h9);
    check("R11", "flush all", {60'd0, s_all, s_proc, s_one, s_ins}, 64'h8);
    wr(6'd44, 64'h9);
    check("R11", "flush proc", {60'd0, s_all, s_proc, s_one, s_ins}, 64'h4);
    @(negedge clk);
    check("R11", "flush strobe ends", {63'd0, fl_proc}, 64'd0);
    wr(6'd48, 64'h0400_0000_0000_0000);   // ASN 0x02
    wr(6'd45, 64'h0000_7FFF_ABCD_E000);
    check("R12", "flush one strobe", {60'd0, s_all, s_proc, s_one, s_ins}, 64'h2);
    check("R12", "flush one addr", s_addr, 64'h0000_7FFF_ABCD_E000);
    check("R12", "flush one asn", {57'd0, s_asn}, 64'h2);
    rd(6'd45); check("R12", "inv one readback", s_rdata, 64'h0000_7FFF_ABCD_E000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scratch();
    t_masks();
    t_clear_and_faults();
    t_cycle();
    t_pte_insert();
    t_flush();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule